// File: doc/BRIEF.md
# Predicated four-way interleaving store unit

This block writes four vector operands of 16-bit elements to memory as a packed array of four-halfword structures. Structure i holds element i of each of the four sources. A predicate carries one bit per element index. A structure whose bit is set goes out as one 64-bit write beat. A structure whose bit is clear produces no beat at all, so its address never reaches the memory side and cannot cause a fault.

The caller supplies a base byte address, a small signed immediate and the number of the first of four consecutive source registers. The block returns the four register indices it needs, wrapping modulo 32. The immediate is scaled by the full store footprint, which is four times the vector length in bytes. A request starts with a one-cycle `start` pulse. Beats go out on a valid/ready write port in ascending structure order. `busy` is high while beats are pending, and a one-cycle `done` follows the last accepted beat.

The sequencer has three states:

- **IDLE** waits for `start`. A start with a non-empty predicate goes to ISSUE; a start with an all-zero predicate goes straight to DONE.
- **ISSUE** presents the lowest pending structure. It stays in ISSUE while `wr_ready` is low or while more structures remain. It goes to DONE when the final pending beat is accepted.
- **DONE** pulses `done` and always returns to IDLE.

Top module: `ist4_store_unit`

## Requirements
- R1: Halfword k (k = 0..3, source order) of a structure lands at byte offset 2k inside the structure, little-endian. Bits [16k+15:16k] of `wr_data` carry element i of source k, and the low byte goes to the lower address.
- R2: The first structure starts at `base_addr + sext(imm) * 4 * VLEN_BITS/8`, modulo 2^ADDR_W. Structure i sits at that address plus 8*i.
- R3: A structure whose predicate bit is 0 gets no write beat and leaves its eight memory bytes unchanged. The number of accepted beats equals the number of set predicate bits.
- R4: Beats are presented in ascending structure index. `wr_be` is 8'hFF whenever `wr_valid` is high and 8'h00 otherwise.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged on the next cycle.
- R6: With `wr_ready` held high and n > 0 active structures, the first beat is valid in the cycle after `start` is sampled. Beats follow one per cycle, and `done` is high in cycle n+1 after start.
- R7: With an all-zero predicate, no beat is issued and `done` is high in the cycle right after `start`.
- R8: `done` lasts exactly one cycle and is never high together with `busy`. `busy` is high in every cycle in which a beat is valid.
- R9: A `start` seen while in ISSUE or DONE is ignored. The running request completes with its original operands and mask.
- R10: `src_regs[5k+4:5k]` equals (`first_reg` + k) mod 32 for k = 0..3.
- R11: While reset is held, `busy`, `done` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only in IDLE |
| base_addr | input | ADDR_W | Base byte address |
| imm | input | IMM_W | Signed multiplier of the store footprint |
| first_reg | input | 5 | Number of the first source register |
| src_regs | output | 20 | Four source register numbers, 5 bits each, lowest field first |
| src0_data | input | VLEN_BITS | First source vector |
| src1_data | input | VLEN_BITS | Second source vector |
| src2_data | input | VLEN_BITS | Third source vector |
| src3_data | input | VLEN_BITS | Fourth source vector |
| pred | input | VLEN_BITS/16 | One enable bit per structure |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | ADDR_W | Byte address of the beat |
| wr_data | output | 64 | Four interleaved halfwords |
| wr_be | output | 8 | Byte enables |
| busy | output | 1 | Beats pending |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench counts cycles from the edge that samples `start`. With ready held high, beat j must be valid in cycle j. `done` is due in cycle n+1 for n active structures, and in cycle 1 for an empty mask. The bench drives inputs on the falling edge and samples 5 ns later, before the next rising edge. A beat therefore counts as accepted only when valid and ready are both seen in the same sampled cycle. After `done`, one more cycle is sampled to confirm that `done` and `busy` have dropped. The memory window is compared with the arithmetic model only after that.

// File: rtl/ist4_pkg.sv
package ist4_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } ist4_state_e;

    localparam int HALF_W       = 16;
    localparam int LANES        = 4;
    localparam int BEAT_W       = HALF_W * LANES;
    localparam int BEAT_BYTES   = BEAT_W / 8;
    localparam int REG_NUM_W    = 5;

    function automatic logic [REG_NUM_W-1:0] reg_step(input logic [REG_NUM_W-1:0] r,
                                                     input int unsigned k);
        return r + REG_NUM_W'(k);
    endfunction

endpackage

// File: rtl/ist4_addr_gen.sv
module ist4_addr_gen #(
    parameter int ADDR_W    = 32,
    parameter int IMM_W     = 4,
    parameter int VLEN_BITS = 128
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] first_addr
);
    localparam int FOOT_BYTES = (VLEN_BITS / 8) * ist4_pkg::LANES;
    localparam int FOOT_SHIFT = $clog2(FOOT_BYTES);

    logic [ADDR_W-1:0] imm_ext;

    assign imm_ext    = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign first_addr = base_addr + (imm_ext << FOOT_SHIFT);
endmodule

// File: rtl/ist4_first_set.sv
module ist4_first_set #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     mask,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (mask[j]) begin
                idx = IDX_W'(j);
            end
        end
    end

    assign any = |mask;
endmodule

// File: rtl/ist4_lane_pick.sv
module ist4_lane_pick #(
    parameter int VLEN_BITS = 128,
    parameter int IDX_W     = 3
) (
    input  logic [ist4_pkg::LANES-1:0][VLEN_BITS-1:0] vecs,
    input  logic [IDX_W-1:0]                          idx,
    output logic [ist4_pkg::BEAT_W-1:0]               beat
);
    localparam int HW = ist4_pkg::HALF_W;

    for (genvar k = 0; k < ist4_pkg::LANES; k++) begin : g_lane
        assign beat[k*HW +: HW] = vecs[k][idx*HW +: HW];
    end
endmodule

// File: rtl/ist4_store_unit.sv
module ist4_store_unit #(
    parameter int VLEN_BITS = 128,
    parameter int ADDR_W    = 32,
    parameter int IMM_W     = 4,
    parameter int NSTRUCT   = VLEN_BITS / ist4_pkg::HALF_W,
    parameter int IDX_W     = $clog2(NSTRUCT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             base_addr,
    input  logic [IMM_W-1:0]              imm,
    input  logic [4:0]                    first_reg,
    output logic [19:0]                   src_regs,
    input  logic [VLEN_BITS-1:0]          src0_data,
    input  logic [VLEN_BITS-1:0]          src1_data,
    input  logic [VLEN_BITS-1:0]          src2_data,
    input  logic [VLEN_BITS-1:0]          src3_data,
    input  logic [NSTRUCT-1:0]            pred,
    output logic                          wr_valid,
    input  logic                          wr_ready,
    output logic [ADDR_W-1:0]             wr_addr,
    output logic [ist4_pkg::BEAT_W-1:0]   wr_data,
    output logic [ist4_pkg::BEAT_BYTES-1:0] wr_be,
    output logic                          busy,
    output logic                          done
);
    import ist4_pkg::*;

    localparam int STRIDE_SHIFT = $clog2(BEAT_BYTES);

    ist4_state_e state_q, state_d;

    logic [LANES-1:0][VLEN_BITS-1:0] vecs_in, vecs_q;
    logic [NSTRUCT-1:0]              pend_q, pend_clr;
    logic [ADDR_W-1:0]               first_addr, first_q;
    logic [IDX_W-1:0]                cur_idx;
    logic                            cur_any;
    logic [BEAT_W-1:0]               beat;
    logic                            take_start, accept;

    // Source register numbering
    for (genvar k = 0; k < LANES; k++) begin : g_reg
        assign src_regs[k*REG_NUM_W +: REG_NUM_W] = reg_step(first_reg, k);
    end

    assign vecs_in = {src3_data, src2_data, src1_data, src0_data};

    ist4_addr_gen #(
        .ADDR_W   (ADDR_W),
        .IMM_W    (IMM_W),
        .VLEN_BITS(VLEN_BITS)
    ) u_addr (
        .base_addr (base_addr),
        .imm       (imm),
        .first_addr(first_addr)
    );

    ist4_first_set #(
        .N    (NSTRUCT),
        .IDX_W(IDX_W)
    ) u_scan (
        .mask(pend_q),
        .idx (cur_idx),
        .any (cur_any)
    );

    ist4_lane_pick #(
        .VLEN_BITS(VLEN_BITS),
        .IDX_W    (IDX_W)
    ) u_pick (
        .vecs(vecs_q),
        .idx (cur_idx),
        .beat(beat)
    );

    assign take_start = (state_q == ST_IDLE) && start;
    assign accept     = (state_q == ST_ISSUE) && wr_ready;

    always_comb begin
        pend_clr          = pend_q;
        pend_clr[cur_idx] = 1'b0;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (|pred) ? ST_ISSUE : ST_DONE;
                end
            end
            ST_ISSUE: begin
                if (wr_ready && !(|pend_clr)) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Operand capture and pending mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            first_q <= '0;
            vecs_q  <= '0;
        end else if (take_start) begin
            pend_q  <= pred;
            first_q <= first_addr;
            vecs_q  <= vecs_in;
        end else if (accept) begin
            pend_q  <= pend_clr;
        end
    end

    // Outputs
    always_comb begin
        wr_valid = 1'b0;
        wr_addr  = first_q + (ADDR_W'(cur_idx) << STRIDE_SHIFT);
        wr_data  = '0;
        wr_be    = '0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ISSUE: begin
                wr_valid = cur_any;
                wr_data  = beat;
                wr_be    = {BEAT_BYTES{cur_any}};
                busy     = 1'b1;
            end
            ST_DONE: begin
                done     = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/ist4_store_chk.sv
module ist4_store_chk #(
    parameter int NSTRUCT = 8,
    parameter int ADDR_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [NSTRUCT-1:0] pred,
    input logic [19:0]        src_regs,
    input logic               wr_valid,
    input logic               wr_ready,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [63:0]        wr_data,
    input logic [7:0]         wr_be,
    input logic               busy,
    input logic               done
);
    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R4
    be_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_be == 8'hFF);

    // R4
    be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> wr_be == 8'h00);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R6
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !done && (|pred) |=> wr_valid);

    // R7
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !done && !(|pred) |=> done && !wr_valid);

    // R10
    reg_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_regs[9:5] == src_regs[4:0] + 5'd1 && src_regs[19:15] == src_regs[14:10] + 5'd1);
endmodule

bind ist4_store_unit ist4_store_chk #(
    .NSTRUCT(NSTRUCT),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .pred    (pred),
    .src_regs(src_regs),
    .wr_valid(wr_valid),
    .wr_ready(wr_ready),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .busy    (busy),
    .done    (done)
);

// File: tb/ist4_store_unit_tb.sv
module ist4_store_unit_tb;
    localparam int VL    = 128;
    localparam int NS    = 8;
    localparam int AW    = 32;
    localparam int IW    = 4;
    localparam int WSZ   = 2048;
    localparam logic [31:0] WBASE = 32'h0000_0C00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_in = '0;
    logic [IW-1:0] imm_in = '0;
    logic [4:0]    first_reg = '0;
    logic [19:0]   src_regs;
    logic [VL-1:0] v0 = '0, v1 = '0, v2 = '0, v3 = '0;
    logic [NS-1:0] pred_in = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b1;
    logic [AW-1:0] wr_addr;
    logic [63:0]   wr_data;
    logic [7:0]    wr_be;
    logic          busy, done;

    int vecs_applied = 0;
    int miscompares  = 0;
    int cycles       = 0;
    logic [7:0] lfsr = 8'h5B;
    logic [7:0] mem [WSZ];
    logic [7:0] expm[WSZ];

    always #10 clk = ~clk;

    ist4_store_unit #(.VLEN_BITS(VL), .ADDR_W(AW), .IMM_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_in), .imm(imm_in),
        .first_reg(first_reg), .src_regs(src_regs),
        .src0_data(v0), .src1_data(v1), .src2_data(v2), .src3_data(v3),
        .pred(pred_in), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .busy(busy), .done(done)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vecs_applied, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        vecs_applied++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] ev(input int s, input int k, input int i);
        return 16'(s * 37 + k * 4099 + i * 263 + 16'h1234);
    endfunction

    task automatic run_op(input logic [7:0] pm, input logic [3:0] im, input logic [31:0] bs,
                          input int seed, input bit stall, input bit poke);
        logic [31:0] st, a;
        logic [7:0]  rem;
        int beats, lat, n, exp_lat, idx, bad, first_bad;
        bit order_ok, be_ok, busy_ok, got_done;
        logic [7:0] bad_act, bad_exp;
        st = bs + ({{28{im[3]}}, im} << 6);
        @(negedge clk);
        for (int i = 0; i < NS; i++) begin
            v0[16*i +: 16] = ev(seed, 0, i);
            v1[16*i +: 16] = ev(seed, 1, i);
            v2[16*i +: 16] = ev(seed, 2, i);
            v3[16*i +: 16] = ev(seed, 3, i);
        end
        start = 1'b1; pred_in = pm; imm_in = im; base_in = bs;
        rem = pm; beats = 0; lat = 0; got_done = 0;
        order_ok = 1; be_ok = 1; busy_ok = 1;
        for (int c = 1; c <= 400 && !got_done; c++) begin
            @(negedge clk);
            if (poke && c == 2) begin
                start = 1'b1; pred_in = ~pm; v0 = ~v0; v1 = ~v1; v2 = ~v2; v3 = ~v3;
                imm_in = im + 4'd1;
            end else begin
                start = 1'b0;
            end
            if (stall) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                wr_ready = lfsr[0];
            end else begin
                wr_ready = 1'b1;
            end
            #5;
            if (wr_valid) begin
                if (wr_be != 8'hFF) be_ok = 0;
                if (!busy) busy_ok = 0;
            end else if (wr_be != 8'h00) begin
                be_ok = 0;
            end
            if (wr_valid && wr_ready) begin
                idx = -1;
                for (int j = NS - 1; j >= 0; j--) if (rem[j]) idx = j;
                if (idx < 0 || wr_addr != st + 32'(8 * idx)) order_ok = 0;
                if (idx >= 0) rem[idx] = 1'b0;
                beats++;
                for (int b = 0; b < 8; b++) begin
                    a = wr_addr + 32'(b) - WBASE;
                    if (a < WSZ) mem[a] = wr_data[8*b +: 8];
                    else order_ok = 0;
                end
            end
            if (done) begin
                got_done = 1; lat = c;
                if (busy) busy_ok = 0;
            end
        end
        @(negedge clk);
        start = 1'b0; wr_ready = 1'b1;
        #5;
        chk(!done && !busy, "R8", "done/busy after pulse", {done, busy}, 0);
        n = $countones(pm);
        for (int i = 0; i < NS; i++) begin
            if (pm[i]) begin
                for (int k = 0; k < 4; k++) begin
                    a = st + 32'(8 * i + 2 * k) - WBASE;
                    expm[a]     = ev(seed, k, i)[7:0];
                    expm[a + 1] = ev(seed, k, i)[15:8];
                end
            end
        end
        chk(got_done == 1, "R6", "done seen", got_done, 1);
        if (!stall) begin
            exp_lat = (n == 0) ? 1 : n + 1;
            chk(lat == exp_lat, (n == 0) ? "R7" : "R6", "done latency", lat, exp_lat);
        end
        chk(beats == n, "R3", "accepted beats", beats, n);
        chk(order_ok, "R2", "beat addresses in ascending order", order_ok, 1);
        chk(be_ok, "R4", "byte enables", be_ok, 1);
        chk(busy_ok, "R8", "busy during beats", busy_ok, 1);
        bad = 0; first_bad = 0; bad_act = 0; bad_exp = 0;
        for (int j = 0; j < WSZ; j++) begin
            if (mem[j] != expm[j]) begin
                if (bad == 0) begin first_bad = j; bad_act = mem[j]; bad_exp = expm[j]; end
                bad++;
            end
        end
        chk(bad == 0, poke ? "R9" : "R1", $sformatf("memory byte @%0h", first_bad), bad_act, bad_exp);
    endtask

    initial begin
        for (int j = 0; j < WSZ; j++) begin
            mem[j]  = 8'(j) ^ 8'hA5;
            expm[j] = 8'(j) ^ 8'hA5;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #5;
        // R11 reset state
        chk(!busy && !done && !wr_valid, "R11", "outputs in reset", {busy, done, wr_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 register numbering, every first register
        for (int f = 0; f < 32; f++) begin
            first_reg = 5'(f);
            #1;
            for (int k = 0; k < 4; k++) begin
                chk(src_regs[5*k +: 5] == 5'(f + k), "R10", $sformatf("reg %0d lane %0d", f, k),
                    src_regs[5*k +: 5], 5'(f + k));
            end
        end

        // R1 R2 R3 R6 R7: every predicate mask, all immediates, some stalls (R5)
        for (int m = 0; m < 256; m++) begin
            run_op(8'(m), 4'(m), 32'h1000 + 32'(2 * (m % 4)), m, (m % 3) == 0, 1'b0);
        end

        // R2 immediate extremes
        run_op(8'hFF, 4'h8, 32'h1000, 300, 1'b0, 1'b0);
        run_op(8'hFF, 4'h7, 32'h1000, 301, 1'b0, 1'b0);
        run_op(8'hA5, 4'hF, 32'h1006, 302, 1'b1, 1'b0);

        // R9 start during ISSUE and during DONE
        run_op(8'hF0, 4'h0, 32'h1000, 400, 1'b0, 1'b1);
        run_op(8'h01, 4'h1, 32'h1000, 401, 1'b0, 1'b1);
        run_op(8'h3C, 4'h2, 32'h1000, 402, 1'b1, 1'b1);

        report();
    end
endmodule